// File: doc/BRIEF.md
# Sequential Stream Buffer

The block is a single 16-byte line buffer placed between a processor core and off-chip memory. It serves a stream region that the core walks in order, either reading it as input or writing it as output. Software programs a base address, an end offset and an access mode. The core then issues plain read or write accesses, and the buffer supplies the address itself: base plus a running offset that advances after every access.

In read mode an empty line is refilled from memory in one line-wide transfer the first time the core touches it. In write mode a completed line is written back on its own. The core is held off while either transfer is in flight. When the offset reaches the programmed end, the buffer raises a sticky interrupt. In write mode it first writes back any partly written line, with byte enables covering only the bytes the core wrote.

Top module: `stream_buf`

## Requirements
- R1: The line holds 16 bytes. Byte i of the line sits on bits 8i+7:8i of the line-wide memory data buses. Every memory transfer moves one whole line at address base + (offset with its low 4 bits cleared).
- R2: With mode bit 1 clear, accesses are 16 bits wide: read data is the halfword zero-extended to 32 bits, and write data is taken from core_wdata_i[15:0]. With mode bit 1 set, accesses are 32 bits wide. Multi-byte values are little-endian within the line.
- R3: The offset starts at 0 and grows by 2 (16-bit mode) or 4 (32-bit mode) after each completed access (core_req_i high while core_stall_o is low). The line entry used is selected by offset[3:0].
- R4: In read mode (mode bit 0 clear), an access to an empty line issues a memory read of that line. The access completes with the returned data once the transfer is acknowledged. Consuming the last entry of a line marks the line empty again.
- R5: In write mode (mode bit 0 set), the access that writes the final byte of a line starts a write-back with all 16 byte enables set. A line that is not yet complete causes no memory transfer unless the end offset is reached.
- R6: core_stall_o is high while a core request waits for a line fill or write-back. It goes low on the cycle after mem_ack_i. A fresh read line therefore costs the memory latency plus one cycle of stall.
- R7: mem_req_o, mem_we_o and mem_addr_o stay stable from the start of a transfer until the cycle of mem_ack_i, which ends it.
- R8: In read mode, irq_o rises after the access that makes the offset equal the end value. In write mode, that access triggers a write-back of the partial line, enabling only the written bytes, and irq_o rises after its acknowledge. irq_o stays high until a configuration write with select 3.
- R9: A configuration write of the base (select 0) or the end (select 1) resets the offset to 0, marks the line empty and discards unwritten data. The next read access then fetches the line again.
- R10: Configuration select 2 writes the mode: bit 0 is the direction (1 = write) and bit 1 is the width (1 = 32-bit). After reset the mode is read/16-bit, base and end are 0, no transfer is requested, nothing stalls and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration select: 0 base, 1 end, 2 mode, 3 interrupt clear |
| cfg_wdata_i | input | 32 | Configuration write data |
| core_req_i | input | 1 | Core access request; direction comes from the mode |
| core_wdata_i | input | 32 | Core write data |
| core_rdata_o | output | 32 | Core read data, valid when the access completes |
| core_stall_o | output | 1 | Holds the core access while a line transfer is pending |
| mem_req_o | output | 1 | Line transfer request |
| mem_we_o | output | 1 | Transfer direction, 1 = write-back |
| mem_addr_o | output | 32 | Line-aligned transfer address |
| mem_be_o | output | 16 | Byte enables for a write-back |
| mem_wdata_o | output | 128 | Line data for a write-back |
| mem_rdata_i | input | 128 | Line data returned by a fill |
| mem_ack_i | input | 1 | One-cycle acknowledge that ends the transfer |
| irq_o | output | 1 | Sticky end-of-stream interrupt |

## Verification
The assertions rely on three things the surrounding logic must guarantee:
- mem_ack_i is a single-cycle pulse given only while mem_req_o is high.
- Configuration writes happen only when no transfer is pending and the core is not requesting.
- The base is line-aligned and the end offset is a multiple of the access size.

The bench keeps within these rules in the following ways. Its memory responder acknowledges only after the request has been held for a fixed latency, and drops the acknowledge on the next cycle. It issues every configuration write after waiting for the memory port to drain. It programs only aligned bases and ends that are reachable in the chosen mode.

// File: rtl/stream_buf_pkg.sv
package stream_buf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_FLUSH} sb_state_e;
  typedef enum logic [1:0] {
    CFG_BASE    = 2'd0,
    CFG_END     = 2'd1,
    CFG_MODE    = 2'd2,
    CFG_IRQ_CLR = 2'd3
  } sb_cfg_sel_e;
endpackage

// File: rtl/sb_line.sv
module sb_line #(
  parameter int LINE_BYTES = 16,
  parameter int CORE_W     = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fill_i,
  input  logic [LINE_BYTES*8-1:0] fill_data_i,
  input  logic                    wr_i,
  input  logic                    wide_i,
  input  logic [$clog2(LINE_BYTES)-1:0] idx_i,
  input  logic [CORE_W-1:0]       wdata_i,
  input  logic                    clr_mask_i,
  output logic [CORE_W-1:0]       rdata_o,
  output logic [LINE_BYTES*8-1:0] line_o,
  output logic [LINE_BYTES-1:0]   mask_o
);
  localparam int IDX_W    = $clog2(LINE_BYTES);
  localparam int WIDE_B   = CORE_W / 8;
  localparam int NARROW_B = WIDE_B / 2;
  localparam int WB_W     = $clog2(WIDE_B);

  logic [IDX_W-1:0] aidx;
  logic [IDX_W:0]   nbytes;

  // entry aligned to the access size
  assign aidx   = idx_i & ~(wide_i ? IDX_W'(WIDE_B - 1) : IDX_W'(NARROW_B - 1));
  assign nbytes = wide_i ? (IDX_W+1)'(WIDE_B) : (IDX_W+1)'(NARROW_B);

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    logic [IDX_W:0]  pos;
    logic            hit;
    logic [WB_W-1:0] rel;
    logic [7:0]      data_q;
    logic            mask_q;

    assign pos = (IDX_W+1)'(b);
    assign hit = wr_i && (pos >= {1'b0, aidx}) && (pos < ({1'b0, aidx} + nbytes));
    assign rel = pos[WB_W-1:0] - aidx[WB_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        mask_q <= 1'b0;
      end else begin
        if (fill_i)     data_q <= fill_data_i[8*b +: 8];
        else if (hit)   data_q <= wdata_i[{rel, 3'b000} +: 8];
        if (clr_mask_i) mask_q <= 1'b0;
        else if (hit)   mask_q <= 1'b1;
      end
    end

    assign line_o[8*b +: 8] = data_q;
    assign mask_o[b]        = mask_q;
  end

  assign rdata_o = wide_i ? line_o[{aidx, 3'b000} +: CORE_W]
                          : {{(CORE_W/2){1'b0}}, line_o[{aidx, 3'b000} +: CORE_W/2]};
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import stream_buf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 16,
  parameter int LINE_BYTES = 16,
  parameter int CORE_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              core_req_i,
  input  logic              mem_ack_i,
  output logic              stall_o,
  output logic              acc_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              wr_mode_o,
  output logic              wide_o,
  output logic              fill_o,
  output logic              clr_mask_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              irq_o
);
  localparam int IDX_W    = $clog2(LINE_BYTES);
  localparam int WIDE_B   = CORE_W / 8;
  localparam int NARROW_B = WIDE_B / 2;

  sb_state_e         state_q;
  logic [ADDR_W-1:0] base_q;
  logic [OFF_W-1:0]  end_q, off_q, lineoff_q, step, off_nx, line_base;
  logic              wr_mode_q, wide_q, valid_q, bnd_q, irq_q;
  logic              restart, need_fill, line_end, hit_end, irq_set, irq_clr;

  assign restart   = cfg_we_i && (cfg_sel_i == CFG_BASE || cfg_sel_i == CFG_END);
  assign irq_clr   = cfg_we_i && (cfg_sel_i == CFG_IRQ_CLR);
  assign step      = wide_q ? OFF_W'(WIDE_B) : OFF_W'(NARROW_B);
  assign off_nx    = off_q + step;
  assign line_end  = (off_nx[IDX_W-1:0] == '0);
  assign hit_end   = (off_nx == end_q);
  assign line_base = {off_q[OFF_W-1:IDX_W], {IDX_W{1'b0}}};
  assign need_fill = !wr_mode_q && !valid_q;
  assign stall_o   = core_req_i && ((state_q != ST_IDLE) || need_fill);
  assign acc_o     = core_req_i && !stall_o;
  assign irq_set   = (acc_o && !wr_mode_q && hit_end)
                   || (state_q == ST_FLUSH && mem_ack_i && bnd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      base_q    <= '0;
      end_q     <= '0;
      off_q     <= '0;
      lineoff_q <= '0;
      wr_mode_q <= 1'b0;
      wide_q    <= 1'b0;
      valid_q   <= 1'b0;
      bnd_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (core_req_i && need_fill && !restart) begin
            state_q   <= ST_FILL;
            lineoff_q <= line_base;
          end else if (acc_o && wr_mode_q && (line_end || hit_end)) begin
            state_q   <= ST_FLUSH;
            lineoff_q <= line_base;
            bnd_q     <= hit_end;
          end
        end
        ST_FILL:  if (mem_ack_i) state_q <= ST_IDLE;
        ST_FLUSH: if (mem_ack_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase

      if (restart) begin
        off_q   <= '0;
        valid_q <= 1'b0;
      end else begin
        if (state_q == ST_FILL && mem_ack_i) valid_q <= 1'b1;
        if (acc_o) begin
          off_q <= off_nx;
          if (!wr_mode_q && line_end) valid_q <= 1'b0;
        end
      end

      if (cfg_we_i && cfg_sel_i == CFG_BASE) base_q <= cfg_wdata_i;
      if (cfg_we_i && cfg_sel_i == CFG_END)  end_q  <= cfg_wdata_i[OFF_W-1:0];
      if (cfg_we_i && cfg_sel_i == CFG_MODE) {wide_q, wr_mode_q} <= cfg_wdata_i[1:0];

      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign off_o      = off_q;
  assign wr_mode_o  = wr_mode_q;
  assign wide_o     = wide_q;
  assign fill_o     = (state_q == ST_FILL) && mem_ack_i;
  assign clr_mask_o = ((state_q == ST_FLUSH) && mem_ack_i) || restart;
  assign mem_req_o  = (state_q != ST_IDLE);
  assign mem_we_o   = (state_q == ST_FLUSH);
  assign mem_addr_o = base_q + ADDR_W'(lineoff_q);
  assign irq_o      = irq_q;
endmodule

// File: rtl/stream_buf.sv
module stream_buf #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 16,
  parameter int LINE_BYTES = 16,
  parameter int CORE_W     = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [1:0]              cfg_sel_i,
  input  logic [ADDR_W-1:0]       cfg_wdata_i,
  input  logic                    core_req_i,
  input  logic [CORE_W-1:0]       core_wdata_i,
  output logic [CORE_W-1:0]       core_rdata_o,
  output logic                    core_stall_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [LINE_BYTES-1:0]   mem_be_o,
  output logic [LINE_BYTES*8-1:0] mem_wdata_o,
  input  logic [LINE_BYTES*8-1:0] mem_rdata_i,
  input  logic                    mem_ack_i,
  output logic                    irq_o
);
  localparam int IDX_W = $clog2(LINE_BYTES);

  logic             acc_w, wr_mode_w, wide_w, fill_w, clr_mask_w;
  logic [OFF_W-1:0] off_w;

  sb_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINE_BYTES(LINE_BYTES), .CORE_W(CORE_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_sel_i  (cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i),
    .core_req_i (core_req_i),
    .mem_ack_i  (mem_ack_i),
    .stall_o    (core_stall_o),
    .acc_o      (acc_w),
    .off_o      (off_w),
    .wr_mode_o  (wr_mode_w),
    .wide_o     (wide_w),
    .fill_o     (fill_w),
    .clr_mask_o (clr_mask_w),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .irq_o      (irq_o)
  );

  sb_line #(.LINE_BYTES(LINE_BYTES), .CORE_W(CORE_W)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fill_i     (fill_w),
    .fill_data_i(mem_rdata_i),
    .wr_i       (acc_w && wr_mode_w),
    .wide_i     (wide_w),
    .idx_i      (off_w[IDX_W-1:0]),
    .wdata_i    (core_wdata_i),
    .clr_mask_i (clr_mask_w),
    .rdata_o    (core_rdata_o),
    .line_o     (mem_wdata_o),
    .mask_o     (mem_be_o)
  );
endmodule

// File: rtl/stream_buf_chk.sv
module stream_buf_chk #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 16,
  parameter int LINE_BYTES = 16,
  parameter int CORE_W     = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cfg_we_i,
  input logic [1:0]            cfg_sel_i,
  input logic                  core_req_i,
  input logic                  core_stall_o,
  input logic                  mem_req_o,
  input logic                  mem_we_o,
  input logic                  mem_ack_i,
  input logic [ADDR_W-1:0]     mem_addr_o,
  input logic [LINE_BYTES-1:0] mem_be_o,
  input logic                  irq_o,
  input logic                  acc_i,
  input logic                  wide_i,
  input logic [OFF_W-1:0]      off_i
);
  localparam int WIDE_B   = CORE_W / 8;
  localparam int NARROW_B = WIDE_B / 2;

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R7

  AST_STALL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_req_i && mem_req_o |-> core_stall_o); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !(cfg_we_i && cfg_sel_i == 2'd3) |=> irq_o); // R8

  AST_OFF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !cfg_we_i |=> off_i == $past(off_i) + ($past(wide_i) ? OFF_W'(WIDE_B) : OFF_W'(NARROW_B))); // R3

  AST_FLUSH_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_be_o != '0); // R5

  AST_CFG_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && (cfg_sel_i == 2'd0 || cfg_sel_i == 2'd1) |=> off_i == '0); // R9
endmodule

bind stream_buf stream_buf_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINE_BYTES(LINE_BYTES), .CORE_W(CORE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_sel_i   (cfg_sel_i),
  .core_req_i  (core_req_i),
  .core_stall_o(core_stall_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .irq_o       (irq_o),
  .acc_i       (acc_w),
  .wide_i      (wide_w),
  .off_i       (off_w)
);

// File: tb/stream_buf_bench.sv
`timescale 1ns/1ps
module stream_buf_bench;
  localparam int LAT = 3;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cfg_we_i = 1'b0;
  logic [1:0]   cfg_sel_i = '0;
  logic [31:0]  cfg_wdata_i = '0;
  logic         core_req_i = 1'b0;
  logic [31:0]  core_wdata_i = '0;
  logic [31:0]  core_rdata_o;
  logic         core_stall_o;
  logic         mem_req_o, mem_we_o;
  logic [31:0]  mem_addr_o;
  logic [15:0]  mem_be_o;
  logic [127:0] mem_wdata_o;
  logic [127:0] mem_rdata_i = '0;
  logic         mem_ack_i = 1'b0;
  logic         irq_o;

  always #2 clk_i = ~clk_i;

  stream_buf u_stream_buf (.*);

  int tests = 0, fails = 0;
  logic [7:0] mem  [1024];
  logic [7:0] refm [1024];

  // behavioural reference state
  logic [31:0] m_base = 0;
  logic [15:0] m_end = 0, m_off = 0, m_mask = 0;
  logic m_wide = 0, m_wr = 0, m_valid = 0, m_irq = 0, pend_irq = 0;
  logic [31:0] xq_addr[$];
  logic        xq_we[$];
  logic [15:0] xq_be[$];
  logic        xq_irq[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    case (sel)
      2'd0: begin m_base = d; m_off = 0; m_valid = 0; m_mask = 0; end
      2'd1: begin m_end = d[15:0]; m_off = 0; m_valid = 0; m_mask = 0; end
      2'd2: begin m_wr = d[0]; m_wide = d[1]; end
      default: m_irq = 0;
    endcase
  endtask

  task automatic access(input logic [31:0] wd, output logic [31:0] rd, output int stalls);
    int nb;
    logic [31:0] line_a, a, exp;
    nb = m_wide ? 4 : 2;
    line_a = m_base + {16'h0, m_off[15:4], 4'h0};
    a = m_base + {16'h0, m_off};
    if (!m_wr && !m_valid) begin
      xq_addr.push_back(line_a); xq_we.push_back(1'b0);
      xq_be.push_back(16'h0); xq_irq.push_back(1'b0);
      m_valid = 1;
    end
    core_wdata_i = wd;
    core_req_i = 1'b1;
    #1;
    stalls = 0;
    while (core_stall_o) begin
      stalls++;
      @(negedge clk_i);
      #1;
    end
    rd = core_rdata_o;
    @(negedge clk_i);
    core_req_i = 1'b0;
    if (!m_wr) begin
      exp = {16'h0, refm[(a+1)&1023], refm[a&1023]};
      if (m_wide) exp[31:16] = {refm[(a+3)&1023], refm[(a+2)&1023]};
      chk("R2/R3 read data", rd, exp);
    end else begin
      for (int i = 0; i < nb; i++) begin
        refm[(a+i)&1023] = wd[8*i +: 8];
        m_mask[m_off[3:0]+i] = 1'b1;
      end
    end
    m_off = m_off + 16'(nb);
    if (!m_wr) begin
      if (m_off[3:0] == 0) m_valid = 0;
      if (m_off == m_end) m_irq = 1;
    end else if (m_off[3:0] == 0 || m_off == m_end) begin
      xq_addr.push_back(line_a); xq_we.push_back(1'b1);
      xq_be.push_back(m_mask); xq_irq.push_back(m_off == m_end);
      m_mask = 0;
    end
  endtask

  task automatic wait_idle();
    while (mem_req_o || mem_ack_i || xq_addr.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // memory responder and per-clock interrupt comparison
  initial begin
    int cnt;
    logic [9:0] a;
    cnt = 0;
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (mem_ack_i) begin
          mem_ack_i = 1'b0;
          if (pend_irq) m_irq = 1;
          pend_irq = 0;
        end else if (mem_req_o) begin
          cnt++;
          if (cnt == LAT) begin
            cnt = 0;
            a = mem_addr_o[9:0];
            if (xq_addr.size() == 0) begin
              chk("R4/R5 unexpected transfer", mem_addr_o, 32'hFFFF_FFFF);
            end else begin
              chk("R1/R7 transfer address", mem_addr_o, xq_addr[0]);
              chk("R7 transfer direction", {31'h0, mem_we_o}, {31'h0, xq_we[0]});
              if (xq_we[0]) chk("R5 byte enables", {16'h0, mem_be_o}, {16'h0, xq_be[0]});
              pend_irq = xq_irq[0];
              void'(xq_addr.pop_front()); void'(xq_we.pop_front());
              void'(xq_be.pop_front());   void'(xq_irq.pop_front());
            end
            for (int i = 0; i < 16; i++) begin
              if (mem_we_o && mem_be_o[i]) mem[(a+i)&1023] = mem_wdata_o[8*i +: 8];
              mem_rdata_i[8*i +: 8] = mem[(a+i)&1023];
            end
            mem_ack_i = 1'b1;
          end
        end else begin
          cnt = 0;
        end
        #1;
        chk("R8 irq per clock", {31'h0, irq_o}, {31'h0, m_irq});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int st;
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 8'(i * 7 + 3);
      refm[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk("R10 reset mem_req", {31'h0, mem_req_o}, 32'h0);
    chk("R10 reset irq", {31'h0, irq_o}, 32'h0);
    core_req_i = 1'b1; #0.5;
    chk("R10 reset read mode stalls on empty line", {31'h0, core_stall_o}, 32'h1);
    core_req_i = 1'b0; #0.1;
    chk("R10 no stall without request", {31'h0, core_stall_o}, 32'h0);

    // 16-bit read stream over two lines up to the end offset
    cfg(2'd2, 32'h0); cfg(2'd0, 32'h100); cfg(2'd1, 32'h18);
    for (int i = 0; i < 12; i++) begin
      access(32'h0, rd, st);
      if (i == 0) chk("R4/R6 fill stall cycles", st, LAT + 1);
      if (i == 1) chk("R6 hit has no stall", st, 0);
      if (i == 8) chk("R4 second line refill stall", st, LAT + 1);
    end
    chk("R8 read boundary irq", {31'h0, irq_o}, 32'h1);
    cfg(2'd3, 32'h0);
    chk("R8 irq cleared", {31'h0, irq_o}, 32'h0);

    // reprogramming restarts the stream
    cfg(2'd1, 32'h40);
    for (int i = 0; i < 3; i++) access(32'h0, rd, st);
    cfg(2'd1, 32'h40);
    access(32'h0, rd, st);
    chk("R9 restart refetches line", st, LAT + 1);
    chk("R9 restart offset zero data", rd, {16'h0, refm[32'h101], refm[32'h100]});

    // 32-bit read stream
    cfg(2'd2, 32'h2); cfg(2'd0, 32'h200); cfg(2'd1, 32'h20);
    for (int i = 0; i < 8; i++) access(32'h0, rd, st);
    chk("R8 32-bit boundary irq", {31'h0, irq_o}, 32'h1);
    cfg(2'd3, 32'h0);

    // 32-bit write stream, three full lines
    cfg(2'd2, 32'h3); cfg(2'd0, 32'h300); cfg(2'd1, 32'h30);
    for (int i = 0; i < 12; i++) begin
      access(32'hA050_0000 + 32'(i) * 32'h0103_0507, rd, st);
      if (i == 4) chk("R6 write stalls behind write-back", {31'h0, st > 0}, 32'h1);
    end
    wait_idle();
    chk("R8 write boundary irq after write-back", {31'h0, irq_o}, 32'h1);
    cfg(2'd3, 32'h0);

    // 16-bit partial line ends at the boundary
    cfg(2'd2, 32'h1); cfg(2'd0, 32'h380); cfg(2'd1, 32'h0A);
    for (int i = 0; i < 4; i++) access(32'hC3C3_0000 | 32'(i * 32'h1111), rd, st);
    chk("R5 no write-back for incomplete line", {31'h0, mem_req_o}, 32'h0);
    access(32'h0000_5A5A, rd, st);
    wait_idle();
    chk("R8 partial write-back irq", {31'h0, irq_o}, 32'h1);

    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] !== refm[i]) bad++;
      chk("R5/R8 memory image", bad, 0);
    end
    finish_run();
  end
endmodule